// File: doc/BRIEF.md
# Prescaled Alarm Timer with Reload

This block is a general-purpose hardware timer. A programmable prescaler turns the input clock into one step enable every N clocks, and each step moves a 64-bit counter up or down by one. Software configures the timer through a simple register port. It sets the divider, the control bits, a 64-bit alarm value and a 64-bit reload value. It can read the counter at any time, either through the register port or on a dedicated output bus.

When the alarm is armed and a step brings the counter onto the alarm value, the alarm fires. A sticky status bit is set. If interrupts are enabled, a one-cycle pulse appears on `irq_o`. If reload is enabled, the counter takes the reload value in place of the matched value and the alarm stays armed for the next match. If reload is off, the counter keeps the matched value and the alarm disarms itself, so it fires only once.

Top module: `tick_alarm_timer`

## Requirements
- R1: After reset the counter is 0, the control word reads 0, the divider reads 2, the status bit reads 0 and `irq_o` is low.
- R2: While the run bit is set, the counter takes one step every N clocks, where N is the divider register (address 1, bits 15:0). The first step comes N clocks after the write that sets run.
- R3: A divider write of 0 or 1 is stored and read back as 2. Any other value is stored unchanged.
- R4: The control word is at address 0 and its bit 0 is run. While run is clear the counter holds its value and the prescaler restarts from zero.
- R5: Control bit 1 selects the direction: 0 counts up and 1 counts down. The counter wraps modulo 2^64 in both directions.
- R6: Control bit 2 arms the alarm. While it is clear, no counter value ever fires the alarm.
- R7: An armed alarm fires when a step produces a value equal to the alarm register (address 2 holds the low word, address 3 the high word). Firing sets status bit 0 at address 6. When control bit 4 is set, firing also raises `irq_o` for exactly one cycle, in the same cycle the counter updates.
- R8: When control bit 3 (reload) is set, a firing step loads the reload register (address 4 holds the low word, address 5 the high word) in place of the matched value, and the alarm stays armed.
- R9: When reload is clear, a firing step leaves the matched value in the counter and clears control bit 2 by itself.
- R10: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged. If a fire and a clear happen in the same cycle, the fire wins.
- R11: The counter is always visible on `count_o`. It can also be read at address 7 (low word) and address 8 (high word).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| count_o | output | 64 | Current counter value |
| irq_o | output | 1 | One-cycle alarm interrupt pulse |

## Verification
Directed runs each arm one combination of the reload and interrupt-enable bits against a small alarm value, then count interrupt pulses over a fixed window. This separates repeating alarms from one-shot alarms, and alarms that raise a pulse from alarms that only set status. A down-count run from zero separates correct wrap-around from a counter that saturates, and the divider readbacks show the clamp of 0 and 1. Random phases then rewrite the control word, the divider and alarm values placed near the live count, checking against a bench model every cycle. This catches ordering faults: a divider changed mid-count, a write that lands on the same edge as a fire, and a run bit toggled between steps.

// File: rtl/atmr_pkg.sv
package atmr_pkg;

    localparam int unsigned ADDR_W = 4;

    // register offsets
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_DIV    = 4'd1;
    localparam logic [ADDR_W-1:0] A_ALM_LO = 4'd2;
    localparam logic [ADDR_W-1:0] A_ALM_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 4'd4;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 4'd5;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd6;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd7;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd8;

    // control word, LSB is run
    typedef struct packed {
        logic irq_en;
        logic reload_en;
        logic alarm_en;
        logic down;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/atmr_prescale.sv
module atmr_prescale
    import atmr_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] pc;
    } psc_t;

    psc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // ">=" keeps a mid-count shrink of the divider from running on to wrap
        tick = run && (st_q.pc >= (div - DIV_W'(1)));
        if (!run || tick) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = st_q.pc + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/atmr_regs.sv
module atmr_regs
    import atmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fire,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  div,
    output logic [CNT_W-1:0]  alarm,
    output logic [CNT_W-1:0]  reload,
    output logic              status
);

    localparam int unsigned NWORDS = CNT_W / DATA_W;
    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] alarm;
        logic [CNT_W-1:0] reload;
        logic             stat;
    } regs_t;

    regs_t st_d, st_q;
    logic [DIV_W-1:0] div_w;

    always_comb begin
        st_d  = st_q;
        div_w = wdata[DIV_W-1:0];
        if (div_w < DIV_MIN) begin
            div_w = DIV_MIN;
        end

        // one-shot alarm disarms itself; a same-cycle software write overrides below
        if (fire && !st_q.ctrl.reload_en) begin
            st_d.ctrl.alarm_en = 1'b0;
        end

        if (we) begin
            if (addr == A_CTRL) begin
                st_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
            end
            if (addr == A_DIV) begin
                st_d.div = div_w;
            end
            for (int w = 0; w < NWORDS; w++) begin
                if (addr == A_ALM_LO + ADDR_W'(w)) begin
                    st_d.alarm[w*DATA_W +: DATA_W] = wdata;
                end
                if (addr == A_RLD_LO + ADDR_W'(w)) begin
                    st_d.reload[w*DATA_W +: DATA_W] = wdata;
                end
            end
            if (addr == A_STAT && wdata[0]) begin
                st_d.stat = 1'b0;
            end
        end

        // a fire outranks a clear in the same cycle
        if (fire) begin
            st_d.stat = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.div  <= DIV_MIN;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl   = st_q.ctrl;
    assign div    = st_q.div;
    assign alarm  = st_q.alarm;
    assign reload = st_q.reload;
    assign status = st_q.stat;

endmodule

// File: rtl/atmr_count.sv
module atmr_count
    import atmr_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] alarm,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             fire,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        st_d = st_q;
        nxt  = ctrl.down ? (st_q.cnt - CNT_W'(1)) : (st_q.cnt + CNT_W'(1));
        fire = tick && ctrl.alarm_en && (nxt == alarm);
        if (tick) begin
            st_d.cnt = (fire && ctrl.reload_en) ? reload : nxt;
        end
        st_d.irq = fire && ctrl.irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign irq = st_q.irq;

endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
    import atmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIV_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [3:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [2*DATA_W-1:0] count_o,
    output logic                irq_o
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] reload_q;
    logic             stat_q;
    logic             tick;
    logic             fire;
    logic [CNT_W-1:0] cnt;

    atmr_regs #(
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .fire   (fire),
        .ctrl   (ctrl_q),
        .div    (div_q),
        .alarm  (alarm_q),
        .reload (reload_q),
        .status (stat_q)
    );

    atmr_prescale #(
        .DIV_W (DIV_W)
    ) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q.run),
        .div   (div_q),
        .tick  (tick)
    );

    atmr_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .ctrl   (ctrl_q),
        .alarm  (alarm_q),
        .reload (reload_q),
        .cnt    (cnt),
        .fire   (fire),
        .irq    (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_q;
            A_DIV:    reg_rdata[DIV_W-1:0]  = div_q;
            A_ALM_LO: reg_rdata = alarm_q[DATA_W-1:0];
            A_ALM_HI: reg_rdata = alarm_q[CNT_W-1:DATA_W];
            A_RLD_LO: reg_rdata = reload_q[DATA_W-1:0];
            A_RLD_HI: reg_rdata = reload_q[CNT_W-1:DATA_W];
            A_STAT:   reg_rdata[0] = stat_q;
            A_CNT_LO: reg_rdata = cnt[DATA_W-1:0];
            A_CNT_HI: reg_rdata = cnt[CNT_W-1:DATA_W];
            default:  reg_rdata = '0;
        endcase
    end

    assign count_o = cnt;

endmodule

// File: rtl/atmr_chk.sv
module atmr_chk
    import atmr_pkg::*;
#(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             fire,
    input logic             irq,
    input logic             status,
    input ctrl_t            ctrl,
    input logic [DIV_W-1:0] div,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             we,
    input logic [3:0]       addr
);

    // R3
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div >= DIV_W'(2));

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R4
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |=> $stable(cnt));

    // R5
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !fire && !ctrl.down) |=> cnt == $past(cnt) + CNT_W'(1));

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7
    irq_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status);

    // R8
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ctrl.reload_en) |=> cnt == $past(reload));

    // R9
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ctrl.reload_en && !(we && addr == A_CTRL)) |=> !ctrl.alarm_en);

endmodule

bind tick_alarm_timer atmr_chk #(
    .CNT_W (2 * DATA_W),
    .DIV_W (DIV_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .fire   (fire),
    .irq    (irq_o),
    .status (stat_q),
    .ctrl   (ctrl_q),
    .div    (div_q),
    .cnt    (cnt),
    .reload (reload_q),
    .we     (reg_we),
    .addr   (reg_addr)
);

// File: tb/sim_tick_alarm_timer.sv
module sim_tick_alarm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] count_o;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit cmp_on  = 1'b0;

    always #10 clk = ~clk;

    tick_alarm_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .count_o   (count_o),
        .irq_o     (irq_o)
    );

    // ---------------- bench model built from the requirements ----------------
    logic [4:0]  m_ctrl;
    logic [15:0] m_div;
    logic [63:0] m_alarm, m_reload, m_cnt;
    logic [15:0] m_psc;
    logic        m_stat, m_irq;

    function automatic logic [15:0] clamp_div(input logic [15:0] v);
        return (v < 16'd2) ? 16'd2 : v;
    endfunction

    always @(posedge clk) begin
        logic tk, fr;
        logic [63:0] nx;
        if (!rst_n) begin
            m_ctrl = '0; m_div = 16'd2; m_alarm = '0; m_reload = '0;
            m_cnt = '0; m_psc = '0; m_stat = 1'b0; m_irq = 1'b0;
        end else begin
            tk = m_ctrl[0] && (m_psc >= m_div - 16'd1);
            nx = m_ctrl[1] ? m_cnt - 64'd1 : m_cnt + 64'd1;
            fr = tk && m_ctrl[2] && (nx == m_alarm);
            m_psc = (!m_ctrl[0] || tk) ? 16'd0 : m_psc + 16'd1;
            m_irq = fr && m_ctrl[4];
            if (tk) m_cnt = (fr && m_ctrl[3]) ? m_reload : nx;
            if (fr && !m_ctrl[3]) m_ctrl[2] = 1'b0;
            if (reg_we) begin
                case (reg_addr)
                    4'd0: m_ctrl = reg_wdata[4:0];
                    4'd1: m_div = clamp_div(reg_wdata[15:0]);
                    4'd2: m_alarm[31:0] = reg_wdata;
                    4'd3: m_alarm[63:32] = reg_wdata;
                    4'd4: m_reload[31:0] = reg_wdata;
                    4'd5: m_reload[63:32] = reg_wdata;
                    4'd6: if (reg_wdata[0]) m_stat = 1'b0;
                    default: ;
                endcase
            end
            if (fr) m_stat = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model (R2 R5 R7 R11)
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check(count_o == m_cnt, "R2/R5 count vs model", count_o, m_cnt);
            check(irq_o == m_irq, "R7 irq vs model", {63'd0, irq_o}, {63'd0, m_irq});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_window(input int cyc, output int pulses);
        pulses = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (irq_o) pulses++;
        end
    endtask

    // setup for the alarm tests: divider 2, alarm value 3, reload value 0
    task automatic alarm_setup();
        do_reset();
        wr(4'd1, 32'd2);
        wr(4'd2, 32'd3);
        wr(4'd3, 32'd0);
        wr(4'd4, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int p;
        void'($urandom(32'd1234));
        do_reset();

        // R1 reset state
        check(count_o == 64'd0, "R1 count", count_o, 0);
        check(irq_o == 1'b0, "R1 irq", {63'd0, irq_o}, 0);
        rd(4'd0, rv); check(rv == 32'd0, "R1 ctrl", {32'd0, rv}, 0);
        rd(4'd1, rv); check(rv == 32'd2, "R1 div", {32'd0, rv}, 2);
        rd(4'd6, rv); check(rv == 32'd0, "R1 status", {32'd0, rv}, 0);

        // R3 divider clamp
        wr(4'd1, 32'd0); rd(4'd1, rv); check(rv == 32'd2, "R3 div 0", {32'd0, rv}, 2);
        wr(4'd1, 32'd1); rd(4'd1, rv); check(rv == 32'd2, "R3 div 1", {32'd0, rv}, 2);
        wr(4'd1, 32'd5); rd(4'd1, rv); check(rv == 32'd5, "R3 div 5", {32'd0, rv}, 5);

        // R2 divide by 4: ten steps in forty clocks
        wr(4'd1, 32'd4);
        wr(4'd0, 32'd1);
        repeat (39) @(negedge clk);
        check(count_o == 64'd9, "R2 count before 10th step", count_o, 9);
        @(negedge clk);
        check(count_o == 64'd10, "R2 count after 40 clocks", count_o, 10);

        // R4 stop holds
        wr(4'd0, 32'd0);
        repeat (20) @(negedge clk);
        check(count_o == 64'd10, "R4 hold while stopped", count_o, 10);
        // R11 register readback of the counter
        rd(4'd7, rv); check(rv == 32'd10, "R11 count low word", {32'd0, rv}, 10);
        rd(4'd8, rv); check(rv == 32'd0, "R11 count high word", {32'd0, rv}, 0);

        // R5 down count wraps from zero
        do_reset();
        wr(4'd0, 32'd3);
        repeat (10) @(negedge clk);
        check(count_o == 64'hFFFF_FFFF_FFFF_FFFB, "R5 down wrap", count_o,
              64'hFFFF_FFFF_FFFF_FFFB);
        rd(4'd8, rv); check(rv == 32'hFFFF_FFFF, "R11 high word after wrap",
                            {32'd0, rv}, 64'hFFFF_FFFF);

        // R8 repeating alarm with reload and interrupt
        alarm_setup();
        wr(4'd0, 32'd29);
        run_window(30, p);
        check(p == 5, "R8 pulses with reload", p, 5);
        check(count_o == 64'd0, "R8 count reloaded", count_o, 0);
        rd(4'd0, rv); check(rv[2] == 1'b1, "R8 alarm stays armed", {63'd0, rv[2]}, 1);

        // R9 one-shot alarm
        alarm_setup();
        wr(4'd0, 32'd21);
        run_window(30, p);
        check(p == 1, "R9 single pulse", p, 1);
        check(count_o == 64'd15, "R9 count keeps going", count_o, 15);
        rd(4'd0, rv); check(rv == 32'h11, "R9 alarm disarmed", {32'd0, rv}, 32'h11);
        rd(4'd6, rv); check(rv == 32'd1, "R7 status set", {32'd0, rv}, 1);

        // R10 status write-one-to-clear
        wr(4'd6, 32'd0); rd(4'd6, rv);
        check(rv == 32'd1, "R10 write 0 keeps status", {32'd0, rv}, 1);
        wr(4'd6, 32'd1); rd(4'd6, rv);
        check(rv == 32'd0, "R10 write 1 clears status", {32'd0, rv}, 0);

        // R6 disarmed alarm never fires
        alarm_setup();
        wr(4'd0, 32'd17);
        run_window(30, p);
        check(p == 0, "R6 no pulse while disarmed", p, 0);
        rd(4'd6, rv); check(rv == 32'd0, "R6 no status while disarmed", {32'd0, rv}, 0);

        // R7 interrupt enable off: status only
        alarm_setup();
        wr(4'd0, 32'd13);
        run_window(30, p);
        check(p == 0, "R7 no pulse with irq off", p, 0);
        rd(4'd6, rv); check(rv == 32'd1, "R7 status with irq off", {32'd0, rv}, 1);
        check(count_o == 64'd0, "R8 reload without irq", count_o, 0);

        // random phase compared to the model every cycle
        do_reset();
        cmp_on = 1'b1;
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: wr(4'd0, {27'd0, 5'($urandom_range(0, 31))});
                1: wr(4'd1, $urandom_range(0, 6));
                2: wr(4'd2, m_cnt[31:0] + $urandom_range(0, 4) - 32'd2);
                3: wr(4'd4, $urandom_range(0, 8));
                4: wr(4'd6, $urandom_range(0, 1));
                default: wr(4'd0, 32'd5 | (32'($urandom_range(0, 1)) << 1)
                                      | (32'($urandom_range(0, 3)) << 3));
            endcase
            repeat ($urandom_range(1, 25)) @(negedge clk);
            rd(4'd6, rv);
            check(rv[0] == m_stat, "R10 status vs model", {63'd0, rv[0]}, {63'd0, m_stat});
            rd(4'd0, rv);
            check(rv[4:0] == m_ctrl, "R9 ctrl vs model", {59'd0, rv[4:0]}, {59'd0, m_ctrl});
        end
        cmp_on = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule